// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital sequencer behind a 10-bit successive-approximation analog-to-digital converter with a 16-way input selector. Software-style controls arrive as ports: a converter-on bit, a start strobe and a cancel strobe for the busy/start bit, a 4-bit input selector, a 2-bit reference selector, a clock-source select and a flag-clear strobe. The block captures the input and reference choice when a conversion starts. It runs one acquire step, ten bit-decision steps and one load step. It reports the 10-bit result split over a high and a low byte, together with a sticky completion flag.

During the bit steps the block presents a trial code to an external DAC and comparator. On each step it reads back one compare bit that says whether the sampled input is at or above the trial code. Steps advance on a divided system clock. As an alternative they advance on a strobe from an internal RC oscillator, and only that source keeps the conversion moving while the chip sleeps. The analog sample-and-hold, the DAC and the comparator lie outside the block.

Top module: `sarAdcCtrl`

## Requirements
- R1: After a conversion the result equals the sampled input code. Bits are decided MSB first: a bit is kept when `cmpIn` is 1, meaning the input is at or above the trial code.
- R2: The result registers are written only at completion. In that same cycle `goBusy` falls and `intFlag` rises.
- R3: With the system clock source a conversion lasts 12 steps of `DIV` clock cycles each. With `DIV`=2, `goBusy` falls exactly 24 edges after the edge that sampled `goSet`.
- R4: Reset clears `goBusy`, `intFlag`, `sampleEn` and `trialCode`, and aborts a running conversion. Reset never writes the result registers, so they keep their previous value.
- R5: `goSet` has no effect while `adcOn` is 0.
- R6: A conversion is aborted by `goClr` or by clearing `adcOn`. The result and `intFlag` stay unchanged.
- R7: `intFlag` stays set until `flagClr`. Starting a new conversion does not clear it.
- R8: Selector codes 0–12 and 14–15 drive `muxSel` with that code and `muxFixed`=0. Code 13 is reserved: it drives `muxFixed`=1 and `muxSel`=0, so the converter sees the negative reference and the result is 0.
- R9: The input selector and reference selector are captured at start. Changes made during a conversion affect neither `muxSel`, `refPosExt`, `refNegExt` nor the result. Reference selector bit 0 gives `refPosExt` and bit 1 gives `refNegExt`.
- R10: With `clkSel`=0, `sleep` freezes progress, and the conversion finishes later by exactly the frozen cycles. With `clkSel`=1, progress follows `rcTick` regardless of `sleep`.
- R11: `resLo` carries result bits 7:0. `resHi` carries result bits 9:8 in its bits 1:0, and its other bits are 0.
- R12: `sampleEn` is high only during the acquire step. The first bit step presents trial code 10'h200, and each later step moves the trial bit one position down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| adcOn | input | 1 | Converter enable |
| goSet | input | 1 | Strobe: start a conversion |
| goClr | input | 1 | Strobe: cancel a running conversion |
| chanSel | input | 4 | Input selector |
| refSel | input | 2 | Reference selector (bit0 positive, bit1 negative external) |
| clkSel | input | 1 | Step source: 0 divided system clock, 1 RC strobe |
| sleep | input | 1 | Chip is in sleep |
| rcTick | input | 1 | Step strobe from internal RC oscillator |
| flagClr | input | 1 | Strobe: clear the completion flag |
| cmpIn | input | 1 | Comparator: input at or above trial code |
| goBusy | output | 1 | Busy/start bit |
| resHi | output | 8 | Result high byte |
| resLo | output | 8 | Result low byte |
| intFlag | output | 1 | Sticky completion flag |
| trialCode | output | 10 | Trial code to DAC |
| sampleEn | output | 1 | Sample-and-hold acquire |
| muxSel | output | 4 | Captured input selector |
| muxFixed | output | 1 | Force converter input to negative reference |
| refPosExt | output | 1 | Use external positive reference |
| refNegExt | output | 1 | Use external negative reference |

## Verification
The converter is driven with the input codes 0, full scale, the two codes either side of mid-scale, and the alternating patterns 10'h2AA and 10'h155. Together these catch a stuck, swapped or wrongly kept bit decision in every position, along with off-by-one errors at the scale ends. The input selector is tried on ordinary, top and internal channels and on the reserved code; the reserved code shows whether the fixed input really replaces the selected one. Directed cases cover aborts by cancel, by disable and by reset, a sleep freeze under each step source, and selector changes during a conversion. Each of these tells apart a design that captures, freezes and protects its result from one that does not.

// File: rtl/sarPkg.sv
package sarPkg;

  localparam int IDX_W = 4;
  localparam logic [3:0] RESERVED_CH = 4'd13;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_BITS = 2'd2,
    PH_LOAD = 2'd3
  } sarPhaseT;

  typedef struct packed {
    logic             capture;
    logic             start;
    logic             decide;
    logic             load;
    logic [IDX_W-1:0] bitIdx;
  } sarStrobeT;

endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarPkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DIV      = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      adcOn,
  input  logic      goSet,
  input  logic      goClr,
  input  logic      clkSel,
  input  logic      sleep,
  input  logic      rcTick,
  output logic      goBusy,
  output logic      sampleEn,
  output sarStrobeT strb
);

  sarPhaseT         phaseQ, phaseD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic             sysTick;
  logic             stepTick;
  logic             busy;

  generate
    if (DIV == 1) begin : g_noDiv
      assign sysTick = !sleep;
    end else begin : g_div
      localparam int DIVW = $clog2(DIV);
      logic [DIVW-1:0] divCnt;
      logic            wrap;
      assign wrap    = (divCnt == DIVW'(DIV - 1));
      assign sysTick = wrap && !sleep;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (strb.capture) begin
          divCnt <= '0;
        end else if (!sleep) begin
          divCnt <= wrap ? '0 : divCnt + 1'b1;
        end
      end
    end
  endgenerate

  assign stepTick = clkSel ? rcTick : sysTick;
  assign busy     = (phaseQ != PH_IDLE);
  assign goBusy   = busy;
  assign sampleEn = (phaseQ == PH_ACQ);

  always_comb begin
    strb   = '0;
    phaseD = phaseQ;
    idxD   = idxQ;
    if (!adcOn || (busy && goClr)) begin
      phaseD = PH_IDLE;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (goSet) begin
            strb.capture = 1'b1;
            phaseD       = PH_ACQ;
          end
        end
        PH_ACQ: begin
          if (stepTick) begin
            strb.start = 1'b1;
            phaseD     = PH_BITS;
            idxD       = IDX_W'(RES_BITS - 1);
          end
        end
        PH_BITS: begin
          if (stepTick) begin
            strb.decide = 1'b1;
            strb.bitIdx = idxQ;
            if (idxQ == '0) phaseD = PH_LOAD;
            else            idxD   = idxQ - 1'b1;
          end
        end
        PH_LOAD: begin
          if (stepTick) begin
            strb.load = 1'b1;
            phaseD    = PH_IDLE;
          end
        end
        default: phaseD = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      idxQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      idxQ   <= idxD;
    end
  end

  AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBusy) |-> $past(adcOn && goSet)); // R5

  AST_OFF_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    !adcOn |=> !goBusy); // R6

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sleep && !clkSel && adcOn && !goClr) |=> ($stable(phaseQ) && $stable(idxQ))); // R10

  AST_SAMPLE_ONLY_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |-> !sampleEn); // R12

endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobeT           strb,
  input  logic                cmpIn,
  input  logic [3:0]          chanSel,
  input  logic [1:0]          refSel,
  input  logic                flagClr,
  output logic [RES_BITS-1:0] trialCode,
  output logic [7:0]          resHi,
  output logic [7:0]          resLo,
  output logic                intFlag,
  output logic [3:0]          muxSel,
  output logic                muxFixed,
  output logic                refPosExt,
  output logic                refNegExt
);

  localparam int HI_BITS = RES_BITS - 8;

  logic [RES_BITS-1:0] sarQ, sarNext;
  logic [RES_BITS-1:0] result;
  logic [3:0]          chanQ;
  logic [1:0]          refQ;
  logic                flagQ;

  always_comb begin
    sarNext = sarQ;
    for (int i = 0; i < RES_BITS; i++) begin
      if (IDX_W'(i) == strb.bitIdx)          sarNext[i] = sarQ[i] & cmpIn;
      else if (IDX_W'(i + 1) == strb.bitIdx) sarNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ <= '0;
    end else if (strb.capture) begin
      sarQ <= '0;
    end else if (strb.start) begin
      sarQ <= RES_BITS'(1) << (RES_BITS - 1);
    end else if (strb.decide) begin
      sarQ <= sarNext;
    end
  end

  // Result pair is deliberately outside reset: reset never writes it.
  always_ff @(posedge clk) begin
    if (strb.load) result <= sarQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strb.load) begin
      flagQ <= 1'b1;
    end else if (flagClr) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ <= '0;
      refQ  <= '0;
    end else if (strb.capture) begin
      chanQ <= chanSel;
      refQ  <= refSel;
    end
  end

  assign trialCode = sarQ;
  assign intFlag   = flagQ;
  assign resLo     = result[7:0];
  assign resHi     = {{(8 - HI_BITS){1'b0}}, result[RES_BITS-1:8]};
  assign muxFixed  = (chanQ == RESERVED_CH);
  assign muxSel    = muxFixed ? 4'd0 : chanQ;
  assign refPosExt = refQ[0];
  assign refNegExt = refQ[1];

  AST_RES_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(result)); // R2

  AST_LOAD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> intFlag); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClr) |=> intFlag); // R7

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(muxSel) && $stable(refPosExt) && $stable(refNegExt))); // R9

endmodule

// File: rtl/sarAdcCtrl.sv
module sarAdcCtrl
  import sarPkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DIV      = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adcOn,
  input  logic       goSet,
  input  logic       goClr,
  input  logic [3:0] chanSel,
  input  logic [1:0] refSel,
  input  logic       clkSel,
  input  logic       sleep,
  input  logic       rcTick,
  input  logic       flagClr,
  input  logic       cmpIn,
  output logic       goBusy,
  output logic [7:0] resHi,
  output logic [7:0] resLo,
  output logic       intFlag,
  output logic [9:0] trialCode,
  output logic       sampleEn,
  output logic [3:0] muxSel,
  output logic       muxFixed,
  output logic       refPosExt,
  output logic       refNegExt
);

  sarStrobeT strb;

  sarCtrl #(.RES_BITS(RES_BITS), .DIV(DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .adcOn    (adcOn),
    .goSet    (goSet),
    .goClr    (goClr),
    .clkSel   (clkSel),
    .sleep    (sleep),
    .rcTick   (rcTick),
    .goBusy   (goBusy),
    .sampleEn (sampleEn),
    .strb     (strb)
  );

  sarDatapath #(.RES_BITS(RES_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpIn     (cmpIn),
    .chanSel   (chanSel),
    .refSel    (refSel),
    .flagClr   (flagClr),
    .trialCode (trialCode),
    .resHi     (resHi),
    .resLo     (resLo),
    .intFlag   (intFlag),
    .muxSel    (muxSel),
    .muxFixed  (muxFixed),
    .refPosExt (refPosExt),
    .refNegExt (refNegExt)
  );

endmodule

// File: tb/sarAdcCtrl_tb.sv
`timescale 1ns/1ps
module sarAdcCtrl_tb;

  localparam int DIV = 2;
  localparam int CONV = 12 * DIV;
  localparam int NV = 11;
  // {channel[3:0], input code[9:0]}
  localparam logic [13:0] VEC [NV] = '{
    {4'd0,  10'd0},   {4'd1,  10'd1023}, {4'd2,  10'd512}, {4'd3,  10'd511},
    {4'd4,  10'h2AA}, {4'd5,  10'h155},  {4'd6,  10'd1},   {4'd12, 10'd777},
    {4'd14, 10'd300}, {4'd15, 10'd620},  {4'd13, 10'd700}
  };

  logic       clk = 0, rstN = 0, adcOn = 0, goSet = 0, goClr = 0;
  logic [3:0] chanSel = 0;
  logic [1:0] refSel = 0;
  logic       clkSel = 0, sleep = 0, rcTick = 0, flagClr = 0, cmpIn;
  logic       goBusy, intFlag, sampleEn, muxFixed, refPosExt, refNegExt;
  logic [7:0] resHi, resLo;
  logic [9:0] trialCode;
  logic [3:0] muxSel;
  logic [9:0] ana [16];
  int checks = 0, fails = 0;
  logic [9:0] prevRes;

  always #4 clk = ~clk;

  assign cmpIn = (muxFixed ? 10'd0 : ana[muxSel]) >= trialCode;

  sarAdcCtrl #(.DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .adcOn(adcOn), .goSet(goSet), .goClr(goClr),
    .chanSel(chanSel), .refSel(refSel), .clkSel(clkSel), .sleep(sleep),
    .rcTick(rcTick), .flagClr(flagClr), .cmpIn(cmpIn), .goBusy(goBusy),
    .resHi(resHi), .resLo(resLo), .intFlag(intFlag), .trialCode(trialCode),
    .sampleEn(sampleEn), .muxSel(muxSel), .muxFixed(muxFixed),
    .refPosExt(refPosExt), .refNegExt(refNegExt)
  );

  function automatic logic [9:0] res();
    return {resHi[1:0], resLo};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClr();
    flagClr = 1; cyc(1); flagClr = 0;
  endtask

  // Returns at the negedge after the edge that sampled goSet.
  task automatic startConv(input logic [3:0] ch);
    chanSel = ch; goSet = 1; cyc(1); goSet = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ana[i] = 10'd0;
    cyc(3);
    chk(goBusy == 0 && intFlag == 0, "R4 reset busy/flag", {goBusy, intFlag}, 0);
    chk(trialCode == 0 && sampleEn == 0, "R4 reset trial/sample", {trialCode, sampleEn}, 0);
    rstN = 1; cyc(1);

    // R5: start while disabled
    startConv(4'd2); cyc(30);
    chk(goBusy == 0 && intFlag == 0, "R5 start ignored when off", {goBusy, intFlag}, 0);
    adcOn = 1; cyc(1);

    // Vector walk: R1 R2 R3 R8 R11
    for (int v = 0; v < NV; v++) begin
      logic [3:0] ch;
      logic [9:0] vin, exp;
      ch = VEC[v][13:10]; vin = VEC[v][9:0];
      exp = (ch == 4'd13) ? 10'd0 : vin;
      ana[ch] = vin;
      pulseClr();
      startConv(ch);
      chk(muxFixed == (ch == 4'd13), "R8 fixed input", muxFixed, ch == 4'd13);
      chk(muxSel == ((ch == 4'd13) ? 4'd0 : ch), "R8 selector", muxSel, ch);
      cyc(CONV - 1);
      chk(goBusy == 1 && intFlag == 0, "R3 busy before end", {goBusy, intFlag}, 2);
      cyc(1);
      chk(goBusy == 0, "R3 duration", goBusy, 0);
      chk(intFlag == 1, "R2 flag with result", intFlag, 1);
      chk(res() == exp, "R1 result", res(), exp);
      chk(resHi[7:2] == 0, "R11 high byte layout", resHi, exp >> 8);
    end

    // R12: acquire then MSB-first trial codes
    ana[2] = 10'd300; pulseClr();
    startConv(4'd2);
    chk(sampleEn == 1 && trialCode == 0, "R12 acquire", {sampleEn, trialCode}, 1024);
    cyc(DIV);
    chk(sampleEn == 0 && trialCode == 10'h200, "R12 first trial", trialCode, 10'h200);
    cyc(DIV);
    chk(trialCode == 10'h100, "R12 second trial", trialCode, 10'h100);
    cyc(CONV - 2 * DIV);
    chk(goBusy == 0 && res() == 10'd300, "R1 result 300", res(), 300);
    prevRes = res();

    // R7: flag survives a new conversion, clears on flagClr
    ana[3] = 10'd900;
    startConv(4'd3); cyc(4);
    chk(intFlag == 1, "R7 flag kept at start", intFlag, 1);
    cyc(CONV - 4);
    chk(intFlag == 1 && res() == 10'd900, "R7 flag after second", res(), 900);
    pulseClr();
    chk(intFlag == 0, "R7 cleared", intFlag, 0);
    prevRes = res();

    // R6: abort by cancel
    ana[4] = 10'd55;
    startConv(4'd4); cyc(9);
    goClr = 1; cyc(1); goClr = 0;
    chk(goBusy == 0, "R6 cancel stops", goBusy, 0);
    cyc(40);
    chk(res() == prevRes && intFlag == 0, "R6 cancel keeps result", res(), prevRes);

    // R6: abort by disable
    startConv(4'd4); cyc(11);
    adcOn = 0; cyc(1); adcOn = 1;
    chk(goBusy == 0, "R6 disable stops", goBusy, 0);
    cyc(40);
    chk(res() == prevRes && intFlag == 0, "R6 disable keeps result", res(), prevRes);

    // R4: reset mid conversion
    startConv(4'd4); cyc(13);
    rstN = 0; cyc(2);
    chk(goBusy == 0 && intFlag == 0, "R4 reset aborts", {goBusy, intFlag}, 0);
    chk(res() == prevRes, "R4 result untouched", res(), prevRes);
    rstN = 1; cyc(40);
    chk(res() == prevRes && goBusy == 0, "R4 stays aborted", res(), prevRes);

    // R9: selector changes during conversion
    ana[5] = 10'd444; ana[6] = 10'd11;
    refSel = 2'b11;
    startConv(4'd5);
    chanSel = 4'd6; refSel = 2'b00; cyc(6);
    chk(muxSel == 4'd5, "R9 selector held", muxSel, 5);
    chk(refPosExt == 1 && refNegExt == 1, "R9 reference held", {refPosExt, refNegExt}, 3);
    cyc(CONV - 6);
    chk(res() == 10'd444, "R9 result from start channel", res(), 444);

    // R10: sleep freezes system-clock stepping
    ana[7] = 10'd613; pulseClr();
    startConv(4'd7); cyc(5);
    sleep = 1; cyc(40);
    chk(goBusy == 1, "R10 frozen in sleep", goBusy, 1);
    sleep = 0;
    cyc(CONV + 40 - 1 - 45);
    chk(goBusy == 1, "R10 not yet done", goBusy, 1);
    cyc(1);
    chk(goBusy == 0 && res() == 10'd613, "R10 delayed finish", res(), 613);

    // R10: RC source keeps going in sleep
    ana[8] = 10'd88; clkSel = 1; rcTick = 1; sleep = 1;
    startConv(4'd8); cyc(11);
    chk(goBusy == 1, "R10 rc busy", goBusy, 1);
    cyc(1);
    chk(goBusy == 0 && res() == 10'd88, "R10 rc finish in sleep", res(), 88);
    sleep = 0; rcTick = 0; clkSel = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule